// File: doc/BRIEF.md
# Two-Port Block Transfer Controller

This block copies a programmed number of bytes between two ports without the CPU taking part. Each port has its own address generator, which holds its address or steps it up or down by one after every transfer. Each port is marked as memory space or I/O space, so one block can cover memory to I/O, memory to memory or I/O to I/O. A direction bit chooses which port is the source. Every transfer reads one byte from the source into an internal latch, then writes that byte to the destination. Each port has a programmable number of wait clocks that stretches its strobe.

The CPU programs the controller through a small register interface. Each port's start address goes into a buffer register that is separate from the working counter. The buffer is copied into the working counter when the channel starts, and again when a block with auto-repeat enabled finishes. A new start address can therefore be written while a block is running.

Before it drives the bus, the controller raises a request and waits for the grant. It can transfer in three modes:

- Byte mode gives back the bus after every byte.
- Burst mode keeps the bus while the peripheral's ready line stays high.
- Continuous mode keeps the bus for the whole block and pauses while ready is low.

A sticky end-of-block flag drives the interrupt output.

Top module: `dma2p`

## Requirements
- R1: Each transfer first strobes a read of the source port, latching the byte present on bus_rdata in its last read cycle. It then strobes a write of that byte to the destination port on bus_wdata. Config bit 6 = 0 makes port A the source; 1 makes port B the source.
- R2: Each port's address after transfer i is its start address when its mode is 0 (fixed), start + i when the mode is 1 (increment) and start - i when the mode is 2 (decrement), all modulo 2^16. The mode field is config bits 1:0 for port A and bits 3:2 for port B.
- R3: bus_mem is 1 while a port marked as memory is addressed and 0 for a port marked as I/O. The I/O marks are config bit 4 for port A and bit 5 for port B.
- R4: After start, exactly L transfers are made, where L is the length register (offset 2). The last transfer sets a sticky end flag that drives irq. Writing the command register (offset 4) with bit 2 set clears the flag.
- R5: bus_rd and bus_wr are only asserted while bus_grant is high, and never together. bus_req falls on the clock that follows the final write cycle of a bus tenure.
- R6: In byte mode (config bits 8:7 = 0), the bus is released after every transfer, so a block of L transfers takes L request tenures.
- R7: In burst mode (config bits 8:7 = 1), transfers continue in one tenure while bus_ready is high. If ready is low when a transfer ends, bus_req drops and no new request is made until ready returns.
- R8: In continuous mode (config bits 8:7 = 2), the whole block runs in one tenure. While ready is low, bus_req stays high and no strobe is issued.
- R9: With wait field W (config bits 11:10 for port A, 13:12 for port B), each strobe on that port lasts 1 + W clocks.
- R10: Writing a start address (offset 0 for port A, offset 1 for port B) during a block leaves that block's addresses unchanged. The next start uses the new value.
- R11: With auto-repeat (config bit 9) set, completion reloads both addresses and the count from the buffers, and the same block runs again.
- R12: Writing the command register with bit 1 set stops the channel after the transfer in progress. bus_req falls and the active bit clears. Command bit 0 starts the channel.
- R13: Status at offset 5 reads bit 0 = active, bit 1 = end flag and bit 2 = bus_ready. After reset it reads only the ready bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| bus_req | output | 1 | Bus request |
| bus_grant | input | 1 | Bus grant from the arbiter |
| bus_ready | input | 1 | Peripheral ready |
| bus_addr | output | 16 | Address of the port being strobed |
| bus_mem | output | 1 | 1 = memory space, 0 = I/O space |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data |
| irq | output | 1 | End-of-block interrupt (sticky) |

## Verification
The assertions assume the arbiter raises bus_grant only after bus_req and holds it until bus_req falls. They also assume the configuration stays constant while a block runs. The bench's arbiter follows bus_req half a clock later, so grant never runs ahead of the request. Configuration is written only while the channel is idle. The peripheral model supplies read data as a fixed function of address and space, and it moves ready only at falling edges.

// File: rtl/dma2p_pkg.sv
package dma2p_pkg;
    localparam int AW    = 16;
    localparam int DW    = 8;
    localparam int LW    = 16;
    localparam int RDW   = 16;
    localparam int RAW   = 3;
    localparam int WAITW = 2;
    localparam int NPORT = 2;

    localparam logic [RAW-1:0] OFS_START_A = 3'd0;
    localparam logic [RAW-1:0] OFS_START_B = 3'd1;
    localparam logic [RAW-1:0] OFS_LEN     = 3'd2;
    localparam logic [RAW-1:0] OFS_CFG     = 3'd3;
    localparam logic [RAW-1:0] OFS_CMD     = 3'd4;
    localparam logic [RAW-1:0] OFS_STAT    = 3'd5;

    localparam int CMD_GO   = 0;
    localparam int CMD_HALT = 1;
    localparam int CMD_CLR  = 2;

    typedef enum logic [1:0] {AM_FIXED = 2'd0, AM_INC = 2'd1, AM_DEC = 2'd2, AM_KEEP = 2'd3} amode_e;
    typedef enum logic [1:0] {XM_BYTE = 2'd0, XM_BURST = 2'd1, XM_CONT = 2'd2, XM_SPARE = 2'd3} xmode_e;
    typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR, ST_HOLD} st_e;

    typedef struct packed {
        logic [WAITW-1:0] wait_b;
        logic [WAITW-1:0] wait_a;
        logic             rpt_en;
        xmode_e           xmode;
        logic             dir_ba;
        logic             io_b;
        logic             io_a;
        amode_e           am_b;
        amode_e           am_a;
    } cfg_t;

    localparam int CFGW = $bits(cfg_t);

    function automatic logic [AW-1:0] addr_next(input logic [AW-1:0] a, input amode_e m);
        case (m)
            AM_INC:  addr_next = a + 1'b1;
            AM_DEC:  addr_next = a - 1'b1;
            default: addr_next = a;
        endcase
    endfunction
endpackage

// File: rtl/dma2p_addr_gen.sv
module dma2p_addr_gen
    import dma2p_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          buf_we,
    input  logic [AW-1:0] buf_d,
    input  logic          load,
    input  logic          step,
    input  amode_e        mode,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] start_buf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            start_buf <= '0;
            addr      <= '0;
        end else begin
            if (buf_we) start_buf <= buf_d;
            if (load)      addr <= start_buf;
            else if (step) addr <= addr_next(addr, mode);
        end
    end

    p_buf_no_disturb_r10: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(addr));
    p_fixed_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && mode == AM_FIXED) |=> $stable(addr));
endmodule

// File: rtl/dma2p_regs.sv
module dma2p_regs
    import dma2p_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [RDW-1:0] reg_wdata,
    output logic [RDW-1:0] reg_rdata,
    input  logic [AW-1:0]  buf_a,
    input  logic [AW-1:0]  buf_b,
    input  logic           end_set,
    input  logic           active,
    input  logic           ready,
    output logic [NPORT-1:0] buf_we,
    output cfg_t           cfg,
    output logic [LW-1:0]  len_buf,
    output logic           go,
    output logic           halt,
    output logic           end_flag
);
    logic cmd_we, clr;

    assign cmd_we    = reg_we && (reg_addr == OFS_CMD);
    assign go        = cmd_we && reg_wdata[CMD_GO];
    assign halt      = cmd_we && reg_wdata[CMD_HALT];
    assign clr       = cmd_we && reg_wdata[CMD_CLR];
    assign buf_we[0] = reg_we && (reg_addr == OFS_START_A);
    assign buf_we[1] = reg_we && (reg_addr == OFS_START_B);

    always_ff @(posedge clk) begin
        if (rst) begin
            len_buf  <= '0;
            cfg      <= '0;
            end_flag <= 1'b0;
        end else begin
            if (reg_we && reg_addr == OFS_LEN) len_buf <= reg_wdata[LW-1:0];
            if (reg_we && reg_addr == OFS_CFG) cfg <= cfg_t'(reg_wdata[CFGW-1:0]);
            if (end_set)  end_flag <= 1'b1;
            else if (clr) end_flag <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_START_A: reg_rdata = RDW'(buf_a);
            OFS_START_B: reg_rdata = RDW'(buf_b);
            OFS_LEN:     reg_rdata = RDW'(len_buf);
            OFS_CFG:     reg_rdata = RDW'(cfg);
            OFS_STAT:    reg_rdata = RDW'({ready, end_flag, active});
            default:     reg_rdata = '0;
        endcase
    end

    p_end_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (end_flag && !clr) |=> end_flag);
    p_end_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (clr && !end_set) |=> !end_flag);
endmodule

// File: rtl/dma2p_seq.sv
module dma2p_seq
    import dma2p_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             halt,
    input  xmode_e           xmode,
    input  logic             rpt_en,
    input  logic [WAITW-1:0] wait_src,
    input  logic [WAITW-1:0] wait_dst,
    input  logic [LW-1:0]    len_buf,
    input  logic             bus_grant,
    input  logic             bus_ready,
    input  logic [DW-1:0]    bus_rdata,
    output logic             load,
    output logic             step,
    output logic             bus_req,
    output logic             rd_cyc,
    output logic             wr_cyc,
    output logic             end_pulse,
    output logic             active,
    output logic [DW-1:0]    dlat
);
    st_e              state;
    logic             stop_pend, stop, start_ok, xfer_end, last;
    logic [LW-1:0]    cnt;
    logic [WAITW-1:0] wcnt;

    assign stop      = stop_pend || halt;
    assign start_ok  = go && !active;
    assign last      = (cnt == LW'(1));
    assign xfer_end  = (state == ST_WR) && (wcnt == wait_dst);
    assign step      = xfer_end;
    assign end_pulse = xfer_end && last;
    assign load      = start_ok || (xfer_end && last && rpt_en && !stop);
    assign rd_cyc    = (state == ST_RD);
    assign wr_cyc    = (state == ST_WR);
    assign bus_req   = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            active    <= 1'b0;
            stop_pend <= 1'b0;
            cnt       <= '0;
            wcnt      <= '0;
            dlat      <= '0;
        end else begin
            if (start_ok) begin
                active    <= 1'b1;
                stop_pend <= 1'b0;
                cnt       <= len_buf;
            end else if (halt && active) begin
                stop_pend <= 1'b1;
            end
            case (state)
                ST_IDLE: begin
                    if (active && stop) begin
                        active    <= 1'b0;
                        stop_pend <= 1'b0;
                    end else if (active && bus_ready) begin
                        state <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (stop) begin
                        state     <= ST_IDLE;
                        active    <= 1'b0;
                        stop_pend <= 1'b0;
                    end else if (bus_grant) begin
                        state <= ST_RD;
                        wcnt  <= '0;
                    end
                end
                ST_RD: begin
                    if (wcnt == wait_src) begin
                        dlat  <= bus_rdata;
                        state <= ST_WR;
                        wcnt  <= '0;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_WR: begin
                    if (xfer_end) begin
                        wcnt <= '0;
                        cnt  <= cnt - 1'b1;
                        if (last) begin
                            state <= ST_IDLE;
                            if (rpt_en && !stop) begin
                                cnt <= len_buf;
                            end else begin
                                active    <= 1'b0;
                                stop_pend <= 1'b0;
                            end
                        end else if (stop) begin
                            state     <= ST_IDLE;
                            active    <= 1'b0;
                            stop_pend <= 1'b0;
                        end else begin
                            case (xmode)
                                XM_BURST: state <= bus_ready ? ST_RD : ST_IDLE;
                                XM_CONT:  state <= bus_ready ? ST_RD : ST_HOLD;
                                default:  state <= ST_IDLE;
                            endcase
                        end
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (stop) begin
                        state     <= ST_IDLE;
                        active    <= 1'b0;
                        stop_pend <= 1'b0;
                    end else if (bus_ready) begin
                        state <= ST_RD;
                        wcnt  <= '0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_strobe_grant_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_cyc || wr_cyc) |-> bus_grant);
    p_byte_release_r6: assert property (@(posedge clk) disable iff (rst)
        (xmode == XM_BYTE && xfer_end) |=> !bus_req);
    p_cont_keeps_bus_r8: assert property (@(posedge clk) disable iff (rst)
        (xmode == XM_CONT && xfer_end && !last && !stop) |=> bus_req);
    p_hold_silent_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !bus_ready) |=> (!rd_cyc && !wr_cyc));
endmodule

// File: rtl/dma2p.sv
module dma2p
    import dma2p_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [RDW-1:0] reg_wdata,
    output logic [RDW-1:0] reg_rdata,
    output logic           bus_req,
    input  logic           bus_grant,
    input  logic           bus_ready,
    output logic [AW-1:0]  bus_addr,
    output logic           bus_mem,
    output logic           bus_rd,
    output logic           bus_wr,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    output logic           irq
);
    cfg_t             cfg;
    logic [NPORT-1:0] buf_we;
    logic [AW-1:0]    port_addr [NPORT];
    logic [AW-1:0]    port_buf  [NPORT];
    amode_e           port_mode [NPORT];
    logic [LW-1:0]    len_buf;
    logic             go, halt, load, step, end_pulse, active;
    logic [WAITW-1:0] wait_src, wait_dst;
    logic [AW-1:0]    src_addr, dst_addr;
    logic             src_io, dst_io;

    dma2p_regs u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .buf_a(port_buf[0]), .buf_b(port_buf[1]), .end_set(end_pulse),
        .active(active), .ready(bus_ready), .buf_we(buf_we), .cfg(cfg),
        .len_buf(len_buf), .go(go), .halt(halt), .end_flag(irq)
    );

    assign port_mode[0] = cfg.am_a;
    assign port_mode[1] = cfg.am_b;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dma2p_addr_gen u_ag (
            .clk(clk), .rst(rst), .buf_we(buf_we[p]), .buf_d(reg_wdata[AW-1:0]),
            .load(load), .step(step), .mode(port_mode[p]),
            .addr(port_addr[p]), .start_buf(port_buf[p])
        );
    end

    assign src_addr = cfg.dir_ba ? port_addr[1] : port_addr[0];
    assign dst_addr = cfg.dir_ba ? port_addr[0] : port_addr[1];
    assign src_io   = cfg.dir_ba ? cfg.io_b : cfg.io_a;
    assign dst_io   = cfg.dir_ba ? cfg.io_a : cfg.io_b;
    assign wait_src = cfg.dir_ba ? cfg.wait_b : cfg.wait_a;
    assign wait_dst = cfg.dir_ba ? cfg.wait_a : cfg.wait_b;

    dma2p_seq u_seq (
        .clk(clk), .rst(rst), .go(go), .halt(halt), .xmode(cfg.xmode),
        .rpt_en(cfg.rpt_en), .wait_src(wait_src), .wait_dst(wait_dst),
        .len_buf(len_buf), .bus_grant(bus_grant), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .load(load), .step(step), .bus_req(bus_req),
        .rd_cyc(bus_rd), .wr_cyc(bus_wr), .end_pulse(end_pulse),
        .active(active), .dlat(bus_wdata)
    );

    assign bus_addr = bus_rd ? src_addr : dst_addr;
    assign bus_mem  = bus_rd ? !src_io : !dst_io;

    p_rdwr_excl_r1: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));
    p_wr_after_rd_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_wr) |-> $past(bus_rd));
endmodule

// File: tb/dma2p_bench.sv
module dma2p_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        bus_req, bus_rd, bus_wr, bus_mem, irq;
    logic        bus_grant = 1'b0;
    logic        bus_ready = 1'b1;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;

    int nchk = 0, nfail = 0, cyc = 0;
    int nwr = 0, rdc = 0, wrc = 0, ten = 0;
    logic wr_q = 1'b0, req_q = 1'b0;
    logic [15:0] log_addr [64];
    logic [7:0]  log_data [64];
    logic        log_mem  [64];

    always #10 clk = ~clk;

    dma2p u_dma2p (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
        .bus_grant(bus_grant), .bus_ready(bus_ready), .bus_addr(bus_addr),
        .bus_mem(bus_mem), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [7:0] src_byte(input logic [15:0] a, input logic m);
        return a[7:0] ^ a[15:8] ^ (m ? 8'h00 : 8'h5A);
    endfunction

    function automatic logic [15:0] exp_addr(input logic [15:0] s, input logic [1:0] m, input int i);
        if (m == 2'd1) return s + 16'(i);
        if (m == 2'd2) return s - 16'(i);
        return s;
    endfunction

    assign bus_rdata = src_byte(bus_addr, bus_mem);

    always @(negedge clk) begin
        bus_grant = bus_req;
        if (bus_wr && !wr_q && nwr < 64) begin
            log_addr[nwr] = bus_addr;
            log_data[nwr] = bus_wdata;
            log_mem[nwr]  = bus_mem;
            nwr = nwr + 1;
        end
        if (bus_rd) rdc = rdc + 1;
        if (bus_wr) wrc = wrc + 1;
        if (bus_req && !req_q) ten = ten + 1;
        wr_q  = bus_wr;
        req_q = bus_req;
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog: actual cycles %0d expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wait_writes(input int n);
        for (int k = 0; k < 3000 && nwr < n; k++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_irq();
        for (int k = 0; k < 3000 && !irq; k++) @(negedge clk);
        check("R4 end flag raised", int'(irq), 1);
    endtask

    task automatic clear_logs();
        nwr = 0; rdc = 0; wrc = 0; ten = 0;
    endtask

    task automatic launch(input logic [15:0] cfg, input logic [15:0] a,
                          input logic [15:0] b, input logic [15:0] len);
        reg_wr(3'd0, a);
        reg_wr(3'd1, b);
        reg_wr(3'd2, len);
        reg_wr(3'd3, cfg);
        reg_wr(3'd4, 16'h0004);
        clear_logs();
        reg_wr(3'd4, 16'h0001);
    endtask

    task automatic verify(input logic [15:0] cfg, input logic [15:0] a, input logic [15:0] b,
                          input int first, input int count, input int i0);
        logic dir;
        logic [15:0] ss, ds, sa;
        logic [1:0] sm, dm;
        logic sio, dio;
        dir = cfg[6];
        ss = dir ? b : a;         ds = dir ? a : b;
        sm = dir ? cfg[3:2] : cfg[1:0];
        dm = dir ? cfg[1:0] : cfg[3:2];
        sio = dir ? cfg[5] : cfg[4];
        dio = dir ? cfg[4] : cfg[5];
        for (int i = 0; i < count; i++) begin
            sa = exp_addr(ss, sm, i0 + i);
            check("R1 write data", int'(log_data[first+i]), int'(src_byte(sa, !sio)));
            check("R2 dest address", int'(log_addr[first+i]), int'(exp_addr(ds, dm, i0 + i)));
            check("R3 dest space", int'(log_mem[first+i]), int'(!dio));
        end
    endtask

    localparam int NV = 6;
    localparam logic [79:0] VEC [NV] = '{
        {16'h0005, 16'hFFFE, 16'h1000, 16'd4, 16'd4},
        {16'h0098, 16'h0033, 16'h0002, 16'd5, 16'd1},
        {16'h0166, 16'h2001, 16'h00F0, 16'd6, 16'd1},
        {16'h3821, 16'h0100, 16'h0077, 16'd3, 16'd3},
        {16'h04B0, 16'h0012, 16'h0034, 16'd2, 16'd1},
        {16'h0105, 16'h4444, 16'h8888, 16'd1, 16'd1}
    };

    initial begin : main
        logic [15:0] st, cfg, a, b, len, tn;
        int w_src, w_dst, snap;
        idle(3);
        rst = 1'b0;
        idle(1);

        reg_rd(3'd5, st);
        check("R13 reset status", int'(st), 16'h0004);
        check("R5 reset bus_req", int'(bus_req), 0);
        check("R4 reset irq", int'(irq), 0);

        for (int v = 0; v < NV; v++) begin
            {cfg, a, b, len, tn} = VEC[v];
            launch(cfg, a, b, len);
            wait_irq();
            idle(3);
            check("R4 transfer count", nwr, int'(len));
            verify(cfg, a, b, 0, int'(len), 0);
            w_src = cfg[6] ? int'(cfg[13:12]) : int'(cfg[11:10]);
            w_dst = cfg[6] ? int'(cfg[11:10]) : int'(cfg[13:12]);
            check("R9 read strobe clocks", rdc, int'(len) * (1 + w_src));
            check("R9 write strobe clocks", wrc, int'(len) * (1 + w_dst));
            check("R6 R7 R8 tenures", ten, int'(tn));
            check("R5 request released", int'(bus_req), 0);
            reg_rd(3'd5, st);
            check("R13 status after block", int'(st), 16'h0006);
        end

        reg_wr(3'd4, 16'h0004);
        idle(1);
        check("R4 end flag cleared", int'(irq), 0);

        // R7 burst pause
        launch(16'h0085, 16'h0200, 16'h0300, 16'd6);
        wait_writes(2);
        bus_ready = 1'b0;
        idle(10);
        check("R7 writes before drop", nwr, 2);
        check("R7 bus released on ready low", int'(bus_req), 0);
        bus_ready = 1'b1;
        wait_irq();
        idle(2);
        check("R7 burst tenures", ten, 2);
        verify(16'h0085, 16'h0200, 16'h0300, 0, 6, 0);

        // R8 continuous pause
        launch(16'h0105, 16'h0A00, 16'h0B00, 16'd6);
        wait_writes(2);
        bus_ready = 1'b0;
        idle(1);
        snap = rdc;
        idle(10);
        check("R8 writes during pause", nwr, 2);
        check("R8 no read strobe while paused", rdc, snap);
        check("R8 bus held while paused", int'(bus_req), 1);
        bus_ready = 1'b1;
        wait_irq();
        idle(2);
        check("R8 continuous tenures", ten, 1);
        verify(16'h0105, 16'h0A00, 16'h0B00, 0, 6, 0);

        // R10 buffered start plus R13 active status
        launch(16'h3C05, 16'h0040, 16'h0080, 16'd4);
        wait_writes(1);
        reg_wr(3'd0, 16'h7000);
        reg_rd(3'd5, st);
        check("R13 status while active", int'(st), 16'h0005);
        wait_irq();
        idle(2);
        verify(16'h3C05, 16'h0040, 16'h0080, 0, 4, 0);
        reg_wr(3'd4, 16'h0004);
        clear_logs();
        reg_wr(3'd4, 16'h0001);
        wait_irq();
        idle(2);
        check("R10 second run count", nwr, 4);
        verify(16'h3C05, 16'h7000, 16'h0080, 0, 4, 0);

        // R11 auto-repeat
        launch(16'h0305, 16'h0300, 16'h0400, 16'd3);
        wait_writes(6);
        reg_wr(3'd4, 16'h0002);
        idle(30);
        check("R11 end flag after first pass", int'(irq), 1);
        verify(16'h0305, 16'h0300, 16'h0400, 0, 3, 0);
        verify(16'h0305, 16'h0300, 16'h0400, 3, 3, 0);
        reg_rd(3'd5, st);
        check("R12 inactive after disable", int'(st[0]), 0);

        // R12 disable mid-block
        launch(16'h0105, 16'h0500, 16'h0600, 16'd8);
        wait_writes(3);
        reg_wr(3'd4, 16'h0002);
        idle(20);
        check("R12 writes after disable", nwr, 4);
        check("R12 request dropped", int'(bus_req), 0);
        check("R12 no end flag", int'(irq), 0);
        reg_rd(3'd5, st);
        check("R12 status inactive", int'(st), 16'h0004);
        verify(16'h0105, 16'h0500, 16'h0600, 0, 4, 0);

        summary();
        $finish;
    end
endmodule